// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches up to 32 external request lines that are already synchronous to its clock. For each line it can detect a rising edge, a falling edge, or both. A detected edge latches a pending flag. A level-high interrupt request goes to the parent interrupt controller while any pending flag is set whose line is enabled in the active mask. Software configures the block and services it through a small word-addressed register port: a single-cycle write strobe, and a read strobe whose data appears one cycle later. Pending flags are cleared by writing 1 to them.

Pending status is kept in one of two ways, chosen by a parameter. In split mode there is a rising-pending register and a falling-pending register, and the request output looks at their OR. In shared mode a single pending register collects edges of both kinds. Lines that the build does not implement read back 0 in every register. Software can therefore find which lines exist by writing all ones to a trigger register and reading it back.

While the `sleep_i` input is high, a separate wake mask takes the place of the normal interrupt mask. When the block leaves low-power mode, the normal mask applies again. The trigger selections are never altered. An event pulse is also produced for lines enabled in an event mask.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After power-on reset every register reads 0, `irq_o` is low and `evt_o` is low.
- R2: When the rising trigger bit n (word 2, offset 0x08) is set, a 0-to-1 change of `lines_i[n]` sets bit n of the rising-pending register (word 4, offset 0x10). A 1-to-0 change of a line enabled only for rising edges sets nothing.
- R3: When the falling trigger bit n (word 3, offset 0x0C) is set, a 1-to-0 change of `lines_i[n]` sets bit n of the falling-pending register (word 5, offset 0x14). A line enabled in both trigger registers latches on both edges.
- R4: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged, so writing all ones clears every pending bit. A pending bit never clears in any other way.
- R5: If an edge is detected in the same cycle as a write-1-clear of its bit, the bit stays set.
- R6: Pending bits latch whatever the mask. `irq_o` is high exactly while some pending bit (rising OR falling) is set whose bit in the active mask is 1. The active mask is the interrupt mask (word 0, offset 0x00, 1 = enabled).
- R7: `evt_o` is high for one cycle for each cycle in which a trigger-selected edge is detected on a line whose event mask bit (word 1, offset 0x04) is 1. It does not depend on the interrupt mask.
- R8: Bits of lines outside `IMPL_MASK` read 0 in every register. Writing all ones to the rising trigger register and reading it back returns `IMPL_MASK`.
- R9: While `sleep_i` is high, the wake mask (word 6, offset 0x18) replaces the interrupt mask as the active mask. When `sleep_i` falls, the interrupt mask applies again. Neither entering nor leaving sleep changes any configuration register.
- R10: The word is chosen by `bus_addr_i[4:2]` and `bus_addr_i[1:0]` is ignored. Word 7 reads 0. Read data for the address presented with `bus_re_i` appears on `bus_rdata_o` after the next clock edge and holds until the next read.
- R11: With `SPLIT_PEND` = 0, edges of both kinds set one shared pending register at word 4, and word 5 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| lines_i | input | 32 | Synchronous external request lines |
| sleep_i | input | 1 | Low-power mode: wake mask becomes the active mask |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | 5 | Byte address of the register word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Level-high combined interrupt request |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
A line change driven before clock edge k is sampled at edge k and is detected as an edge at edge k+1. The pending bit and `evt_o` are therefore first visible after edge k+1. A register write at edge k changes `irq_o` right after that edge, and a read strobed at edge k returns the pre-edge register state just after edge k. The bench drives inputs on the falling edge and advances its model at each rising edge using the pre-edge state. It compares every output shortly after that edge, so each result is checked in the cycle it is due. Directed sequences place the edge and the clear in the same cycle, and also switch the sleep input while requests are pending.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // byte address width of the register port
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned WSEL_W = ADDR_W - 2;

  typedef logic [WSEL_W-1:0] word_sel_t;

  // word indices (byte offset = index * 4)
  localparam word_sel_t W_IMR   = 3'd0;
  localparam word_sel_t W_EMR   = 3'd1;
  localparam word_sel_t W_RTRIG = 3'd2;
  localparam word_sel_t W_FTRIG = 3'd3;
  localparam word_sel_t W_RPEND = 3'd4;
  localparam word_sel_t W_FPEND = 3'd5;
  localparam word_sel_t W_WAKE  = 3'd6;

  // number of plain configuration registers
  localparam int unsigned CFG_N = 5;
endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync #(
  parameter int unsigned STAGES = 2  // must be 2 or more
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/eic_sampler.sv
module eic_sampler #(
  parameter int unsigned           NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0]  IMPL_MASK = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);
  logic [NUM_LINES-1:0] cur_q, cur_d;
  logic [NUM_LINES-1:0] old_q, old_d;

  always_comb begin
    cur_d = lines_i & IMPL_MASK;
    old_d = cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      old_q <= '0;
    end else begin
      cur_q <= cur_d;
      old_q <= old_d;
    end
  end

  assign rise_o = cur_q & ~old_q;
  assign fall_o = old_q & ~cur_q;
endmodule

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs
  import eic_pkg::*;
#(
  parameter int unsigned          NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  word_sel_t            word_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic                 sleep_i,
  output logic [NUM_LINES-1:0] imr_o,
  output logic [NUM_LINES-1:0] emr_o,
  output logic [NUM_LINES-1:0] rtrig_o,
  output logic [NUM_LINES-1:0] ftrig_o,
  output logic [NUM_LINES-1:0] wake_o,
  output logic [NUM_LINES-1:0] act_mask_o
);
  localparam word_sel_t CFG_WORD [CFG_N] = '{W_IMR, W_EMR, W_RTRIG, W_FTRIG, W_WAKE};

  logic [NUM_LINES-1:0] cfg_q [CFG_N];

  for (genvar g = 0; g < CFG_N; g++) begin : g_reg
    logic                 en;
    logic [NUM_LINES-1:0] nxt;

    always_comb begin
      en  = we_i && (word_i == CFG_WORD[g]);
      nxt = wdata_i & IMPL_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= '0;
      end else if (en) begin
        cfg_q[g] <= nxt;
      end
    end
  end

  assign imr_o   = cfg_q[0];
  assign emr_o   = cfg_q[1];
  assign rtrig_o = cfg_q[2];
  assign ftrig_o = cfg_q[3];
  assign wake_o  = cfg_q[4];

  assign act_mask_o = sleep_i ? wake_o : imr_o;

  // R9
  cfg_retain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({imr_o, emr_o, rtrig_o, ftrig_o, wake_o}));
endmodule

// File: rtl/eic_pend.sv
module eic_pend #(
  parameter int unsigned NUM_LINES  = 32,
  parameter bit          SPLIT_PEND = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] set_rise_i,
  input  logic [NUM_LINES-1:0] set_fall_i,
  input  logic [NUM_LINES-1:0] clr_rise_i,
  input  logic [NUM_LINES-1:0] clr_fall_i,
  output logic [NUM_LINES-1:0] rise_pend_o,
  output logic [NUM_LINES-1:0] fall_pend_o,
  output logic [NUM_LINES-1:0] any_pend_o
);
  if (SPLIT_PEND) begin : g_split
    logic [NUM_LINES-1:0] rp_q, rp_d;
    logic [NUM_LINES-1:0] fp_q, fp_d;

    always_comb begin
      rp_d = (rp_q & ~clr_rise_i) | set_rise_i;
      fp_d = (fp_q & ~clr_fall_i) | set_fall_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rp_q <= '0;
        fp_q <= '0;
      end else begin
        rp_q <= rp_d;
        fp_q <= fp_d;
      end
    end

    assign rise_pend_o = rp_q;
    assign fall_pend_o = fp_q;

    // R4
    w1c_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(rp_q) & ~rp_q & ~$past(clr_rise_i)) == '0) &&
      (($past(fp_q) & ~fp_q & ~$past(clr_fall_i)) == '0));
    // R5
    edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(set_rise_i | set_fall_i)) |=>
        (((rp_q & $past(set_rise_i)) == $past(set_rise_i)) &&
         ((fp_q & $past(set_fall_i)) == $past(set_fall_i))));
  end else begin : g_shared
    logic [NUM_LINES-1:0] sp_q, sp_d;
    logic                 unused_clr_fall;

    assign unused_clr_fall = ^clr_fall_i;

    always_comb begin
      sp_d = (sp_q & ~clr_rise_i) | set_rise_i | set_fall_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sp_q <= '0;
      end else begin
        sp_q <= sp_d;
      end
    end

    assign rise_pend_o = sp_q;
    assign fall_pend_o = '0;

    // R4
    w1c_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(sp_q) & ~sp_q & ~$past(clr_rise_i)) == '0);
    // R5
    edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(set_rise_i | set_fall_i)) |=>
        ((sp_q & $past(set_rise_i | set_fall_i)) == $past(set_rise_i | set_fall_i)));
  end

  assign any_pend_o = rise_pend_o | fall_pend_o;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned          NUM_LINES  = 32,
  parameter logic [NUM_LINES-1:0] IMPL_MASK  = 32'h007F_FFFF,
  parameter bit                   SPLIT_PEND = 1'b1,
  parameter int unsigned          RST_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 sleep_i,
  input  logic                 bus_we_i,
  input  logic                 bus_re_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [NUM_LINES-1:0] bus_wdata_i,
  output logic [NUM_LINES-1:0] bus_rdata_o,
  output logic                 irq_o,
  output logic                 evt_o
);
  logic                 rst_n;
  word_sel_t            word;
  logic [NUM_LINES-1:0] rise, fall, sel_rise, sel_fall;
  logic [NUM_LINES-1:0] imr, emr, rtrig, ftrig, wake, act_mask;
  logic [NUM_LINES-1:0] clr_rise, clr_fall;
  logic [NUM_LINES-1:0] rpend, fpend, apend;
  logic [NUM_LINES-1:0] rdata_q, rdata_d;
  logic                 evt_q, evt_d;
  logic                 unused_addr;

  assign word        = bus_addr_i[ADDR_W-1:2];
  assign unused_addr = ^bus_addr_i[1:0];

  eic_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  eic_sampler #(.NUM_LINES(NUM_LINES), .IMPL_MASK(IMPL_MASK)) u_smp (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .lines_i (lines_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  eic_cfg_regs #(.NUM_LINES(NUM_LINES), .IMPL_MASK(IMPL_MASK)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .we_i       (bus_we_i),
    .word_i     (word),
    .wdata_i    (bus_wdata_i),
    .sleep_i    (sleep_i),
    .imr_o      (imr),
    .emr_o      (emr),
    .rtrig_o    (rtrig),
    .ftrig_o    (ftrig),
    .wake_o     (wake),
    .act_mask_o (act_mask)
  );

  always_comb begin
    sel_rise = rise & rtrig;
    sel_fall = fall & ftrig;
    clr_rise = (bus_we_i && word == W_RPEND) ? bus_wdata_i : '0;
    clr_fall = (bus_we_i && word == W_FPEND) ? bus_wdata_i : '0;
  end

  eic_pend #(.NUM_LINES(NUM_LINES), .SPLIT_PEND(SPLIT_PEND)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .set_rise_i  (sel_rise),
    .set_fall_i  (sel_fall),
    .clr_rise_i  (clr_rise),
    .clr_fall_i  (clr_fall),
    .rise_pend_o (rpend),
    .fall_pend_o (fpend),
    .any_pend_o  (apend)
  );

  // read mux and event pulse next state
  always_comb begin
    case (word)
      W_IMR:   rdata_d = imr;
      W_EMR:   rdata_d = emr;
      W_RTRIG: rdata_d = rtrig;
      W_FTRIG: rdata_d = ftrig;
      W_RPEND: rdata_d = rpend;
      W_FPEND: rdata_d = fpend;
      W_WAKE:  rdata_d = wake;
      default: rdata_d = '0;
    endcase
    evt_d = |((sel_rise | sel_fall) & emr);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_re_i) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign evt_o       = evt_q;
  assign irq_o       = |(apend & act_mask);

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && !bus_we_i) |=> (irq_o || (sleep_i != $past(sleep_i))));
  // R7
  evt_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_o |-> (|apend));
  // R8
  impl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_rdata_o & ~IMPL_MASK) == '0);
  // R9
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sleep_i && ((apend & wake) == '0)) |-> !irq_o);
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] IMPL       = 32'h007F_FFFF;

  logic        clk;
  logic        rst_n;
  logic [31:0] lines;
  logic        sleep;
  logic        we, re;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata, rdata_sh;
  logic        irq, evt, irq_sh, evt_sh;

  int n_run  = 0;
  int n_fail = 0;

  // model state
  logic [31:0] m_imr, m_emr, m_rt, m_ft, m_wk, m_rp, m_fp, m_sp;
  logic [31:0] m_cur, m_old, m_rd, m_rds;
  logic        m_evt;
  logic [31:0] cur_ln;
  logic        cur_sl;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl #(.IMPL_MASK(IMPL), .SPLIT_PEND(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .sleep_i(sleep),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .evt_o(evt));

  ext_irq_ctrl #(.IMPL_MASK(IMPL), .SPLIT_PEND(1'b0)) dut_sh_i (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .sleep_i(sleep),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata_sh), .irq_o(irq_sh), .evt_o(evt_sh));

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [2:0] w, input bit shared);
    case (w)
      3'd0: return m_imr;
      3'd1: return m_emr;
      3'd2: return m_rt;
      3'd3: return m_ft;
      3'd4: return shared ? m_sp : m_rp;
      3'd5: return shared ? 32'h0 : m_fp;
      3'd6: return m_wk;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input logic [31:0] ln, input logic sl, input logic w_en,
                     input logic r_en, input logic [4:0] ad, input logic [31:0] wd);
    logic [2:0]  w;
    logic [31:0] sr, sf, c10, c14, msk;
    @(negedge clk);
    lines = ln; sleep = sl; we = w_en; re = r_en; addr = ad; wdata = wd;
    @(posedge clk);
    w  = ad[4:2];
    sr = m_cur & ~m_old & m_rt;
    sf = m_old & ~m_cur & m_ft;
    if (r_en) begin
      m_rd  = mread(w, 1'b0);
      m_rds = mread(w, 1'b1);
    end
    c10 = (w_en && w == 3'd4) ? wd : 32'h0;
    c14 = (w_en && w == 3'd5) ? wd : 32'h0;
    m_rp  = (m_rp & ~c10) | sr;
    m_fp  = (m_fp & ~c14) | sf;
    m_sp  = (m_sp & ~c10) | sr | sf;
    m_evt = |((sr | sf) & m_emr);
    if (w_en) begin
      case (w)
        3'd0: m_imr = wd & IMPL;
        3'd1: m_emr = wd & IMPL;
        3'd2: m_rt  = wd & IMPL;
        3'd3: m_ft  = wd & IMPL;
        3'd6: m_wk  = wd & IMPL;
        default: ;
      endcase
    end
    m_old = m_cur;
    m_cur = ln & IMPL;
    #1;
    msk = sl ? m_wk : m_imr;
    chk(irq == |((m_rp | m_fp) & msk), "R6 irq level", {31'b0, irq}, {31'b0, |((m_rp | m_fp) & msk)});
    chk(evt == m_evt, "R7 event pulse", {31'b0, evt}, {31'b0, m_evt});
    chk(rdata == m_rd, "R10 read data", rdata, m_rd);
    chk(irq_sh == |(m_sp & msk), "R11 shared irq", {31'b0, irq_sh}, {31'b0, |(m_sp & msk)});
    chk(rdata_sh == m_rds, "R11 shared read data", rdata_sh, m_rds);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(cur_ln, cur_sl, 1'b0, 1'b0, 5'h0, 32'h0);
  endtask

  task automatic wr(input logic [4:0] ad, input logic [31:0] d);
    cyc(cur_ln, cur_sl, 1'b1, 1'b0, ad, d);
  endtask

  task automatic rd(input logic [4:0] ad, output logic [31:0] v);
    cyc(cur_ln, cur_sl, 1'b0, 1'b1, ad, 32'h0);
    v = rdata;
  endtask

  task automatic setln(input logic [31:0] v);
    cur_ln = v;
    cyc(cur_ln, cur_sl, 1'b0, 1'b0, 5'h0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1-watchdog: run hung act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    {m_imr, m_emr, m_rt, m_ft, m_wk, m_rp, m_fp, m_sp} = '0;
    m_cur = '0; m_old = '0; m_rd = '0; m_rds = '0; m_evt = 1'b0;
    cur_ln = '0; cur_sl = 1'b0;
    rst_n = 1'b0; lines = '0; sleep = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk(irq == 1'b0 && evt == 1'b0, "R1 outputs after reset", {30'b0, irq, evt}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk(v == 32'h0, "R1 register reset value", v, 32'h0);
    end

    // R8: probe implemented lines
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v);
    chk(v == IMPL, "R8 implemented-line probe", v, IMPL);

    wr(5'h08, 32'h3);
    wr(5'h0C, 32'h6);

    // R2: rising edges
    setln(32'h7);
    idle(1);
    rd(5'h10, v);
    chk(v == 32'h3, "R2 rising pending", v, 32'h3);
    rd(5'h14, v);
    chk(v == 32'h0, "R3 no falling pending on rise", v, 32'h0);

    // R3: falling edges
    setln(32'h0);
    idle(1);
    rd(5'h14, v);
    chk(v == 32'h6, "R3 falling pending", v, 32'h6);
    rd(5'h10, v);
    chk(v == 32'h3, "R2 rising pending kept", v, 32'h3);

    // R6: masked pending latched, irq after unmask
    chk(irq == 1'b0, "R6 irq masked", {31'b0, irq}, 32'h0);
    wr(5'h00, 32'h1);
    chk(irq == 1'b1, "R6 irq after unmask", {31'b0, irq}, 32'h1);

    // R4: write-one-to-clear
    wr(5'h10, 32'h2);
    rd(5'h10, v);
    chk(v == 32'h1, "R4 clear one bit", v, 32'h1);
    wr(5'h10, 32'h0);
    rd(5'h10, v);
    chk(v == 32'h1, "R4 write zero no effect", v, 32'h1);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h10, v);
    chk(v == 32'h0, "R4 clear all rising", v, 32'h0);
    rd(5'h14, v);
    chk(v == 32'h0, "R4 clear all falling", v, 32'h0);
    chk(irq == 1'b0, "R4 irq after clear", {31'b0, irq}, 32'h0);

    // R5: edge and clear in the same cycle
    setln(32'h1);
    wr(5'h10, 32'h1);
    rd(5'h10, v);
    chk(v == 32'h1, "R5 edge beats clear", v, 32'h1);
    wr(5'h10, 32'h1);
    rd(5'h10, v);
    chk(v == 32'h0, "R4 plain clear", v, 32'h0);

    // R7: event pulse
    wr(5'h04, 32'h1);
    setln(32'h0);
    chk(evt == 1'b0, "R7 no event on unselected edge", {31'b0, evt}, 32'h0);
    setln(32'h1);
    chk(evt == 1'b0, "R7 no event before detection", {31'b0, evt}, 32'h0);
    idle(1);
    chk(evt == 1'b1, "R7 event pulse high", {31'b0, evt}, 32'h1);
    idle(1);
    chk(evt == 1'b0, "R7 event pulse one cycle", {31'b0, evt}, 32'h0);

    // R9: wake mask in sleep
    chk(irq == 1'b1, "R9 irq before sleep", {31'b0, irq}, 32'h1);
    wr(5'h18, 32'h4);
    cur_sl = 1'b1;
    idle(1);
    chk(irq == 1'b0, "R9 sleep uses wake mask", {31'b0, irq}, 32'h0);
    setln(32'h5);
    idle(1);
    setln(32'h1);
    idle(1);
    chk(irq == 1'b1, "R9 wake line raises irq", {31'b0, irq}, 32'h1);
    cur_sl = 1'b0;
    wr(5'h14, 32'h4);
    idle(1);
    chk(irq == 1'b1, "R9 normal mask restored", {31'b0, irq}, 32'h1);
    rd(5'h00, v);
    chk(v == 32'h1, "R9 interrupt mask kept", v, 32'h1);
    rd(5'h08, v);
    chk(v == 32'h3, "R9 rising trigger kept", v, 32'h3);

    // R10: map details
    rd(5'h1C, v);
    chk(v == 32'h0, "R10 word 7 reads zero", v, 32'h0);
    rd(5'h0B, v);
    chk(v == 32'h3, "R10 low address bits ignored", v, 32'h3);

    // R11: shared pending variant
    wr(5'h10, 32'hFFFF_FFFF);
    setln(32'h6);
    idle(1);
    setln(32'h0);
    idle(1);
    rd(5'h10, v);
    chk(rdata_sh == 32'h6, "R11 shared pending both edges", rdata_sh, 32'h6);
    chk(v == 32'h2, "R2 split rising only", v, 32'h2);
    rd(5'h14, v);
    chk(rdata_sh == 32'h0, "R11 shared word 5 reads zero", rdata_sh, 32'h0);
    chk(v == 32'h6, "R3 split falling", v, 32'h6);

    // constrained random phase, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ln_n, wd_n;
      logic        sl_n, we_n, re_n;
      logic [4:0]  ad_n;
      ln_n = cur_ln ^ ($urandom() & $urandom() & $urandom());
      sl_n = ($urandom_range(0, 15) == 0) ? ~cur_sl : cur_sl;
      we_n = ($urandom_range(0, 3) == 0);
      re_n = $urandom_range(0, 1) == 1;
      ad_n = 5'($urandom_range(0, 31));
      wd_n = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom();
      cur_ln = ln_n;
      cur_sl = sl_n;
      cyc(ln_n, sl_n, we_n, re_n, ad_n, wd_n);
    end

    summary();
    $finish;
  end
endmodule